// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a byte-wide internal register space through a single 32-bit access word. The host writes one word that names the internal address, carries the byte to store and says whether the access is a read or a write. The bridge raises a busy flag and then spends a fixed number of cycles doing the internal access. For a read, the fetched byte shows up in the top byte of the same word once busy drops. A host driver waits for busy to clear, issues the access, waits again, and then takes the result.

Next to the access word, the host port holds a general control word, an interrupt enable word, a write-one-to-clear word and an interrupt status word. The control word carries a soft reset, which holds the internal register space and every status bit at reset, and a two-bit clock mode that is brought out to the clock logic. Two event inputs, one for transmit and one for receive, set sticky status bits. A single interrupt line reports the enabled ones.

Top module: `ibr_top`

## Requirements
- R1: After reset every host word reads zero, `irq` is 0, `blk_rst` is 0 and `clk_mode` is 0.
- R2: A host write to the access word (offset 0x04) while idle and out of soft reset makes busy (access word bit 23) read 1 from the next cycle. Busy stays 1 for exactly ACC_LAT cycles.
- R3: A write access (bit 16 = 1) produces exactly one `reg_we` pulse, in the last busy cycle. The pulse carries the address from bits [7:0] and the data from bits [15:8], and `reg_we` and `reg_re` are never high together.
- R4: A read access (bit 16 = 0) fetches the byte at the address in bits [7:0]. Once busy is 0 the byte reads back in bits [31:24], the address reads back in bits [7:0] and bit 16 reads 0.
- R5: A host write to the access word while busy is 1 is ignored: the running access completes with its own address and data, and no second access follows.
- R6: Status word (offset 0x10) bit 1 is set by `ev_tx` and bit 2 by `ev_rx`, and both stay set. Writing 1 to the same bit of the clear word (offset 0x0C) clears it. An event in the same cycle as the clear leaves the bit set.
- R7: `irq` is high exactly when some status bit is set whose bit in the enable word (offset 0x08, 1 = enabled) is also set.
- R8: While control bit 0 (offset 0x00) is 1, `blk_rst` is 1, busy is 0, access word writes are ignored and status bits stay 0 even when events arrive.
- R9: Control bits [2:1] drive `clk_mode` (0 off, 1 gated normal, 2 free-running debug) and read back from the control word.
- R10: Unused bits of the host words, and offsets outside 0x00–0x10, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| ev_tx | input | 1 | Transmit event pulse |
| ev_rx | input | 1 | Receive event pulse |
| irq | output | 1 | Interrupt line |
| clk_mode | output | 2 | Clock mode select |
| blk_rst | output | 1 | Hold-in-reset for the internal register space |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 8 | Internal write data |
| reg_we | output | 1 | Internal write strobe |
| reg_re | output | 1 | Internal read strobe |
| reg_rdata | input | 8 | Internal read data |

## Verification
On every cycle, the assertions check the following: busy rises after an accepted access write, the single internal strobe arrives only in the final busy cycle, the latched address and data stay still while an access is in flight, status bits stay sticky and clear, and soft reset keeps busy and status at zero. Some behaviour only the bench scenarios can show. These are the end-to-end data path (bytes written and read back through the register space across random addresses), the exact busy length, the rejection of a second command under busy, the irq gating against chosen enable patterns, and the register space coming back empty after a soft reset.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_AW = 5;
  localparam int IRQ_W   = 3;

  localparam logic [HOST_AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [HOST_AW-1:0] OFS_CMD  = 5'h04;
  localparam logic [HOST_AW-1:0] OFS_MASK = 5'h08;
  localparam logic [HOST_AW-1:0] OFS_CLR  = 5'h0C;
  localparam logic [HOST_AW-1:0] OFS_STAT = 5'h10;

  localparam int BIT_WR   = 16;
  localparam int BIT_BUSY = 23;

  // only the transmit (1) and receive (2) interrupt bits exist
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 3'b110;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       wr;
  } acc_cmd_t;

  function automatic acc_cmd_t unpack_cmd(input logic [31:0] w);
    acc_cmd_t c;
    c.addr  = w[7:0];
    c.wdata = w[15:8];
    c.wr    = w[BIT_WR];
    return c;
  endfunction

  function automatic logic [31:0] pack_word(input acc_cmd_t c, input logic busy,
                                            input logic [7:0] rd);
    logic [31:0] w;
    w = '0;
    w[7:0]    = c.addr;
    w[15:8]   = c.wdata;
    w[BIT_WR] = c.wr;
    w[BIT_BUSY] = busy;
    w[31:24]  = rd;
    return w;
  endfunction

  function automatic logic any_enabled(input logic [IRQ_W-1:0] st,
                                       input logic [IRQ_W-1:0] en);
    return |(st & en & IRQ_IMPL);
  endfunction
endpackage

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       cmd_wr,
  input  acc_cmd_t   cmd_in,
  input  logic [7:0] reg_rdata,
  output logic       busy,
  output logic       strobe,
  output acc_cmd_t   cmd_q,
  output logic [7:0] rdata_q
);
  localparam int CW = $clog2(ACC_LAT + 1);
  localparam logic [CW-1:0] LAT_V = CW'(ACC_LAT);

  logic [CW-1:0] cnt;
  logic          accept;

  assign busy   = (cnt != '0);
  assign strobe = (cnt == CW'(1));
  assign accept = cmd_wr && !busy && !srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmd_q   <= '0;
      rdata_q <= '0;
    end else if (srst) begin
      cnt     <= '0;
      cmd_q   <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      cnt   <= LAT_V;
      cmd_q <= cmd_in;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (strobe && !cmd_q.wr) rdata_q <= reg_rdata;
    end
  end
endmodule

// File: rtl/ibr_irq.sv
module ibr_irq
  import ibr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [IRQ_W-1:0] ev,
  input  logic             clr_wr,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] mask
);
  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (IRQ_IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat[i] <= 1'b0;
          mask[i] <= 1'b0;
        end else begin
          if (mask_wr) mask[i] <= wbits[i];
          if (srst)
            stat[i] <= 1'b0;
          else if (ev[i])
            stat[i] <= 1'b1;
          else if (clr_wr && wbits[i])
            stat[i] <= 1'b0;
        end
      end
    end else begin : g_none
      assign stat[i] = 1'b0;
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ibr_top.sv
module ibr_top
  import ibr_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        ev_tx,
  input  logic        ev_rx,
  output logic        irq,
  output logic [1:0]  clk_mode,
  output logic        blk_rst,
  output logic [7:0]  reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [7:0]  reg_rdata
);
  logic [2:0]       ctrl_q;
  logic             soft_rst;
  logic             acc_busy;
  logic             acc_strobe;
  acc_cmd_t         acc_cmd;
  logic [7:0]       acc_rdata;
  logic [IRQ_W-1:0] irq_stat;
  logic [IRQ_W-1:0] irq_mask;
  logic             wr_ctrl, wr_cmd, wr_mask, wr_clr;

  assign wr_ctrl = host_we && (host_addr == OFS_CTRL);
  assign wr_cmd  = host_we && (host_addr == OFS_CMD);
  assign wr_mask = host_we && (host_addr == OFS_MASK);
  assign wr_clr  = host_we && (host_addr == OFS_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= host_wdata[2:0];
  end

  assign soft_rst = ctrl_q[0];
  assign blk_rst  = soft_rst;
  assign clk_mode = ctrl_q[2:1];

  ibr_seq #(.ACC_LAT(ACC_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (soft_rst),
    .cmd_wr    (wr_cmd),
    .cmd_in    (unpack_cmd(host_wdata)),
    .reg_rdata (reg_rdata),
    .busy      (acc_busy),
    .strobe    (acc_strobe),
    .cmd_q     (acc_cmd),
    .rdata_q   (acc_rdata)
  );

  assign reg_addr  = acc_cmd.addr;
  assign reg_wdata = acc_cmd.wdata;
  assign reg_we    = acc_strobe && acc_cmd.wr;
  assign reg_re    = acc_strobe && !acc_cmd.wr;

  ibr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (soft_rst),
    .ev      ({ev_rx, ev_tx, 1'b0}),
    .clr_wr  (wr_clr),
    .mask_wr (wr_mask),
    .wbits   (host_wdata[IRQ_W-1:0]),
    .stat    (irq_stat),
    .mask    (irq_mask)
  );

  assign irq = any_enabled(irq_stat, irq_mask);

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = {29'd0, ctrl_q};
      OFS_CMD:  host_rdata = pack_word(acc_cmd, acc_busy, acc_rdata);
      OFS_MASK: host_rdata = {29'd0, irq_mask};
      OFS_STAT: host_rdata = {29'd0, irq_stat};
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk
  import ibr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             host_we,
  input logic [4:0]       host_addr,
  input logic [31:0]      host_wdata,
  input logic             acc_busy,
  input logic             reg_we,
  input logic             reg_re,
  input logic [7:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [IRQ_W-1:0] irq_stat,
  input logic [IRQ_W-1:0] irq_mask,
  input logic             irq,
  input logic             ev_tx
);
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (host_we && host_addr == OFS_CMD && !acc_busy) |=> acc_busy);

  a_r3_strobe_last: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (reg_we || reg_re) |-> (acc_busy && $onehot0({reg_we, reg_re})));

  a_r3_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (reg_we || reg_re) |=> !acc_busy);

  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (acc_busy && !(reg_we || reg_re)) |=> ($stable(reg_addr) && $stable(reg_wdata)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (irq_stat[1] && !(host_we && host_addr == OFS_CLR && host_wdata[1])) |=> irq_stat[1]);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == OFS_CLR && host_wdata[1] && !ev_tx) |=> !irq_stat[1]);

  a_r7_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) && soft_rst |-> (!acc_busy && irq_stat == '0));
endmodule

bind ibr_top ibr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .acc_busy   (acc_busy),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq_stat   (irq_stat),
  .irq_mask   (irq_mask),
  .irq        (irq),
  .ev_tx      (ev_tx)
);

// File: tb/tb_ibr_top.sv
module tb_ibr_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ev_tx = 1'b0, ev_rx = 1'b0;
  logic        irq, blk_rst, reg_we, reg_re;
  logic [1:0]  clk_mode;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;

  int checks = 0, errors = 0, we_pulses = 0;
  logic done = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  ibr_top #(.ACC_LAT(LAT)) dut (.*);

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (blk_rst) for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    else if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_we) we_pulses <= we_pulses + 1;
  end

  function automatic logic [31:0] cmd(input logic [7:0] a, input logic [7:0] d,
                                      input logic wr);
    return {8'h00, 7'h00, wr, d, a};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] w;
    rd(5'h04, w);
    while (w[23]) begin
      @(negedge clk);
      rd(5'h04, w);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic [7:0] d, input logic w,
                        output logic [31:0] res, output int blen);
    logic [31:0] x;
    wait_idle();
    wr(5'h04, cmd(a, d, w));
    blen = 0;
    rd(5'h04, x);
    while (x[23] && blen < 100) begin
      blen++;
      @(negedge clk);
      rd(5'h04, x);
    end
    res = x;
    if (w) model[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bl, p0;
    logic [7:0] a, d;
    void'($urandom(32'h1b7e));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; model[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int o = 0; o <= 16; o += 4) begin
      rd(o[4:0], v);
      chk(v == 0, "R1 word after reset", v, 0);
    end
    chk(!irq && !blk_rst && clk_mode == 0, "R1 outputs", {irq, blk_rst, clk_mode}, 0);

    // R2 busy length, R3 write strobe
    p0 = we_pulses;
    access(8'h12, 8'hA5, 1'b1, v, bl);
    chk(bl == LAT, "R2 busy length", bl, LAT);
    chk(we_pulses - p0 == 1, "R3 one write strobe", we_pulses - p0, 1);
    chk(mem[8'h12] == 8'hA5, "R3 write data/address", mem[8'h12], 8'hA5);

    // R4 read back with field echo
    access(8'h12, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'hA5 && v[7:0] == 8'h12 && !v[16], "R4 read word", v, 32'hA5000012);

    // R5 second command while busy is ignored
    wait_idle();
    p0 = we_pulses;
    wr(5'h04, cmd(8'h30, 8'h11, 1'b1));
    wr(5'h04, cmd(8'h31, 8'h22, 1'b1));
    model[8'h30] = 8'h11;
    wait_idle();
    repeat (LAT + 2) @(negedge clk);
    chk(we_pulses - p0 == 1, "R5 no second access", we_pulses - p0, 1);
    access(8'h31, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'h00, "R5 busy write ignored", v[31:24], 0);
    access(8'h30, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'h11, "R5 running access intact", v[31:24], 8'h11);

    // R3/R4 random traffic
    for (int n = 0; n < 60; n++) begin
      a = 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) access(a, d, 1'b1, v, bl);
      else begin
        access(a, 8'h00, 1'b0, v, bl);
        chk(v[31:24] == model[a], "R4 random read", v[31:24], model[a]);
      end
    end
    access(8'hFF, 8'h5C, 1'b1, v, bl);
    access(8'hFF, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'h5C, "R4 top address", v[31:24], 8'h5C);

    // R6 / R7 interrupts
    @(negedge clk); ev_tx = 1'b1; @(negedge clk); ev_tx = 1'b0;
    rd(5'h10, v);
    chk(v == 32'h2, "R6 tx event sets bit1", v, 2);
    chk(!irq, "R7 masked off", irq, 0);
    wr(5'h08, 32'h4);
    chk(!irq, "R7 other bit enabled", irq, 0);
    wr(5'h08, 32'h2);
    chk(irq, "R7 enabled source", irq, 1);
    @(negedge clk); ev_rx = 1'b1; @(negedge clk); ev_rx = 1'b0;
    rd(5'h10, v);
    chk(v == 32'h6, "R6 both sticky", v, 6);
    wr(5'h0C, 32'h2);
    rd(5'h10, v);
    chk(v == 32'h4, "R6 clear bit1 only", v, 4);
    chk(!irq, "R7 after clear", irq, 0);
    @(negedge clk);
    host_we = 1'b1; host_addr = 5'h0C; host_wdata = 32'h4; ev_rx = 1'b1;
    @(negedge clk);
    host_we = 1'b0; ev_rx = 1'b0;
    rd(5'h10, v);
    chk(v == 32'h4, "R6 event beats clear", v, 4);
    wr(5'h0C, 32'h6);
    rd(5'h10, v);
    chk(v == 32'h0, "R6 cleared", v, 0);
    rd(5'h08, v);
    chk(v == 32'h2, "R7 mask readback", v, 2);

    // R9 clock mode
    wr(5'h00, 32'hFFFF_FFF4);
    chk(clk_mode == 2'd2 && !blk_rst, "R9 clk_mode", clk_mode, 2);
    rd(5'h00, v);
    chk(v == 32'h4, "R9/R10 ctrl readback", v, 4);
    rd(5'h14, v);
    chk(v == 32'h0, "R10 unmapped offset", v, 0);

    // R8 soft reset
    wr(5'h00, 32'h3);
    chk(blk_rst, "R8 blk_rst", blk_rst, 1);
    wr(5'h04, cmd(8'h40, 8'h77, 1'b1));
    rd(5'h04, v);
    chk(!v[23], "R8 access ignored", v, 0);
    @(negedge clk); ev_tx = 1'b1; @(negedge clk); ev_tx = 1'b0;
    rd(5'h10, v);
    chk(v == 0, "R8 status held", v, 0);
    wr(5'h00, 32'h2);
    chk(clk_mode == 2'd1 && !blk_rst, "R8 release", {clk_mode, blk_rst}, 2);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    access(8'h12, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'h00, "R8 register space reset", v[31:24], 0);
    access(8'h40, 8'h00, 1'b0, v, bl);
    chk(v[31:24] == 8'h00, "R8 command dropped", v[31:24], 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule